// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This unit collects interrupt events for a small in-order core and turns them into a single request for the instruction sequencer. Three core sources each have one enable and one sticky flag in an 8-bit control register: a timer overflow pulse, a rising edge on an external pin, and any change on a 4-bit port nibble. A parameterised group of peripheral sources has a separate enable register and a separate flag register. The combined pending state of that group is masked by a group-enable bit in the control register. A global enable bit then gates every source.

A flag latches when its event occurs, whether or not its enable is set. Only a software write clears a flag. The request is offered to the sequencer while the global enable is set and at least one enabled flag is pending. The sequencer accepts it only at an instruction boundary. On acceptance the unit pulses `irq_take`, presents the fixed vector address, and clears the global enable, so a handler cannot be interrupted. A return-from-interrupt sets the global enable again, and any interrupt still pending is then offered at once. Saving the working and status registers and finding which source fired are left to software.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset, the control register, the peripheral enable register, the peripheral flag register, `irq_req` and `irq_take` all read zero.
- R2: The control register has this bit layout. Bit 7 is the global enable. Bit 6 is the peripheral-group enable. Bit 5 enables the timer source, bit 4 the external pin and bit 3 the port nibble. Bits 2, 1 and 0 are the flags for the timer, the external pin and the port nibble. A write stores all eight bits, and `ctl_rd_data` returns them one cycle later.
- R3: A one-cycle `tmr_ovf_evt` pulse sets bit 2 on the next clock edge even when bit 5 is clear. An event whose enable is clear produces no request.
- R4: When a software write and an event hit the same flag in the same cycle, the event wins and the flag reads 1.
- R5: A rising edge on `ext_pin` sets bit 1 on the third clock edge after the pin changes (two synchronizer flops, then edge detection). A falling edge sets nothing.
- R6: A change in either direction on any bit of `port_hi` sets bit 0 with the same three-edge latency.
- R7: A pulse on `per_evt[i]` sets `pfl_rd[i]` on the next edge, whatever the state of `pen_rd[i]`. The peripheral group requests only when some index has both its enable bit and its flag bit set, and control bit 6 is also set.
- R8: `irq_req` is 1 exactly when bit 7 is set and some enabled source is pending. It stays asserted until the flag or its enable is cleared, or until the interrupt is accepted.
- R9: `irq_take` pulses only in a cycle where both `irq_req` and `insn_boundary` are high. In that cycle `irq_vector` reads 0x0004. On the next edge bit 7 clears and every flag is kept.
- R10: A `retfie` pulse sets bit 7 on the next edge. If a source is still enabled and pending, `irq_req` is high again in the following cycle.
- R11: While bit 7 is clear, `irq_req` stays low whatever the other enables and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 8 | Value written to the control register |
| ctl_rd_data | output | 8 | Current control register contents |
| pen_wr_en | input | 1 | Write strobe for the peripheral enable register |
| pen_wr_data | input | PER_W | Value written to the peripheral enable register |
| pen_rd | output | PER_W | Current peripheral enables |
| pfl_wr_en | input | 1 | Write strobe for the peripheral flag register |
| pfl_wr_data | input | PER_W | Value written to the peripheral flag register |
| pfl_rd | output | PER_W | Current peripheral flags |
| tmr_ovf_evt | input | 1 | Timer overflow pulse, synchronous |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_hi | input | 4 | Watched port nibble, asynchronous |
| per_evt | input | PER_W | Peripheral event pulses, synchronous |
| insn_boundary | input | 1 | High when the sequencer is between instructions |
| retfie | input | 1 | Return-from-interrupt executed |
| irq_req | output | 1 | Interrupt request to the sequencer |
| irq_take | output | 1 | Acceptance pulse |
| irq_vector | output | PC_W | Handler address, valid with `irq_take` |

## Verification
The bound checker watches every cycle for the rules that link state across one clock edge. These are: acceptance clears the global enable, return sets it, a flag stays set without a write, event pulses land in their flags, no request appears while the global enable is clear, and an unserviced request persists. The directed scenarios cover what a single-cycle property cannot show. That includes the exact three-edge latency of the synchronized pin and nibble, the fact that a falling pin edge does nothing, the rule that an event beats a write in the same cycle, the layered masking of the peripheral group, and the way acceptance is held off until a boundary.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int CTL_W   = 8;
    localparam int PORT_W  = 4;
    localparam int SYNC_N  = 2;

    // Bit order fixed: gie=7 ... prt_fl=0
    typedef struct packed {
        logic gie;
        logic peie;
        logic tmr_en;
        logic ext_en;
        logic prt_en;
        logic tmr_fl;
        logic ext_fl;
        logic prt_fl;
    } ctl_reg_t;

    typedef enum logic [1:0] {
        DET_RISE   = 2'd0,
        DET_CHANGE = 2'd1
    } det_mode_e;

    function automatic logic core_pending(input ctl_reg_t c, input logic periph_any);
        return (c.tmr_en & c.tmr_fl) |
               (c.ext_en & c.ext_fl) |
               (c.prt_en & c.prt_fl) |
               (c.peie   & periph_any);
    endfunction

endpackage

// File: rtl/irq_in_cond.sv
module irq_in_cond
    import irq_ctl_pkg::*;
#(
    parameter int        W    = 1,
    parameter det_mode_e MODE = DET_RISE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic         evt
);

    logic [W-1:0] stage [SYNC_N];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_N; i++) stage[i] <= '0;
            prev_q <= '0;
        end else begin
            stage[0] <= async_in;
            for (int i = 1; i < SYNC_N; i++) stage[i] <= stage[i-1];
            prev_q <= stage[SYNC_N-1];
        end
    end

    generate
        if (MODE == DET_CHANGE) begin : g_change
            assign evt = |(stage[SYNC_N-1] ^ prev_q);
        end else begin : g_rise
            assign evt = |(stage[SYNC_N-1] & ~prev_q);
        end
    endgenerate

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             tmr_evt,
    input  logic             ext_evt,
    input  logic             prt_evt,
    input  logic             take,
    input  logic             ret,
    output ctl_reg_t         ctl_q
);

    ctl_reg_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) ctl_d = ctl_reg_t'(wr_data);
        // events outrank a software write
        ctl_d.tmr_fl = ctl_d.tmr_fl | tmr_evt;
        ctl_d.ext_fl = ctl_d.ext_fl | ext_evt;
        ctl_d.prt_fl = ctl_d.prt_fl | prt_evt;
        if (ret)  ctl_d.gie = 1'b1;
        if (take) ctl_d.gie = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

endmodule

// File: rtl/irq_periph_bank.sv
module irq_periph_bank #(
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic [PER_W-1:0] en_data,
    input  logic             fl_wr,
    input  logic [PER_W-1:0] fl_data,
    input  logic [PER_W-1:0] evt,
    output logic [PER_W-1:0] en_q,
    output logic [PER_W-1:0] fl_q,
    output logic             any_pend
);

    genvar g;
    generate
        for (g = 0; g < PER_W; g++) begin : g_src
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_q[g] <= 1'b0;
                    fl_q[g] <= 1'b0;
                end else begin
                    if (en_wr) en_q[g] <= en_data[g];
                    fl_q[g] <= (fl_wr ? fl_data[g] : fl_q[g]) | evt[g];
                end
            end
        end
    endgenerate

    assign any_pend = |(en_q & fl_q);

endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
    import irq_ctl_pkg::*;
#(
    parameter int PER_W = 4,
    parameter int PC_W  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr_en,
    input  logic [7:0]       ctl_wr_data,
    output logic [7:0]       ctl_rd_data,
    input  logic             pen_wr_en,
    input  logic [PER_W-1:0] pen_wr_data,
    output logic [PER_W-1:0] pen_rd,
    input  logic             pfl_wr_en,
    input  logic [PER_W-1:0] pfl_wr_data,
    output logic [PER_W-1:0] pfl_rd,
    input  logic             tmr_ovf_evt,
    input  logic             ext_pin,
    input  logic [3:0]       port_hi,
    input  logic [PER_W-1:0] per_evt,
    input  logic             insn_boundary,
    input  logic             retfie,
    output logic             irq_req,
    output logic             irq_take,
    output logic [PC_W-1:0]  irq_vector
);

    localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(4);

    ctl_reg_t ctl_q;
    logic     ext_evt, prt_evt, periph_any;

    irq_in_cond #(.W(1), .MODE(DET_RISE)) u_ext (
        .clk(clk), .rst(rst), .async_in(ext_pin), .evt(ext_evt)
    );

    irq_in_cond #(.W(PORT_W), .MODE(DET_CHANGE)) u_prt (
        .clk(clk), .rst(rst), .async_in(port_hi), .evt(prt_evt)
    );

    irq_periph_bank #(.PER_W(PER_W)) u_per (
        .clk(clk), .rst(rst),
        .en_wr(pen_wr_en), .en_data(pen_wr_data),
        .fl_wr(pfl_wr_en), .fl_data(pfl_wr_data),
        .evt(per_evt), .en_q(pen_rd), .fl_q(pfl_rd),
        .any_pend(periph_any)
    );

    irq_ctl_regs u_ctl (
        .clk(clk), .rst(rst),
        .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
        .tmr_evt(tmr_ovf_evt), .ext_evt(ext_evt), .prt_evt(prt_evt),
        .take(irq_take), .ret(retfie), .ctl_q(ctl_q)
    );

    assign ctl_rd_data = ctl_q;
    assign irq_req     = ctl_q.gie & core_pending(ctl_q, periph_any);
    assign irq_take    = irq_req & insn_boundary;
    assign irq_vector  = VEC_ADDR;

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
    parameter int PER_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       ctl_rd_data,
    input logic             ctl_wr_en,
    input logic             pen_wr_en,
    input logic             pfl_wr_en,
    input logic [PER_W-1:0] pfl_rd,
    input logic             tmr_ovf_evt,
    input logic [PER_W-1:0] per_evt,
    input logic             retfie,
    input logic             irq_req,
    input logic             irq_take
);

    a_r9_take_clears_gie: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !ctl_rd_data[7]);

    a_r10_ret_sets_gie: assert property (@(posedge clk) disable iff (rst)
        (retfie && !irq_take) |=> ctl_rd_data[7]);

    a_r11_no_req_when_off: assert property (@(posedge clk) disable iff (rst)
        !ctl_rd_data[7] |-> !irq_req);

    a_r3_tmr_flag_latch: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf_evt |=> ctl_rd_data[2]);

    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd_data[2] && !ctl_wr_en) |=> ctl_rd_data[2]);

    a_r7_periph_flag_latch: assert property (@(posedge clk) disable iff (rst)
        (per_evt != '0) |=> ((pfl_rd & $past(per_evt)) == $past(per_evt)));

    a_r8_req_persists: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_take && !ctl_wr_en && !pen_wr_en && !pfl_wr_en) |=> irq_req);

endmodule

bind irq_ctl_unit irq_ctl_chk #(.PER_W(PER_W)) u_chk (
    .clk(clk), .rst(rst), .ctl_rd_data(ctl_rd_data), .ctl_wr_en(ctl_wr_en),
    .pen_wr_en(pen_wr_en), .pfl_wr_en(pfl_wr_en), .pfl_rd(pfl_rd),
    .tmr_ovf_evt(tmr_ovf_evt), .per_evt(per_evt), .retfie(retfie),
    .irq_req(irq_req), .irq_take(irq_take)
);

// File: tb/irq_ctl_unit_bench.sv
module irq_ctl_unit_bench;

    localparam int CLK_P = 10;
    localparam int PER_W = 4;
    localparam int PC_W  = 13;

    logic             clk = 1'b0;
    logic             rst;
    logic             ctl_wr_en;
    logic [7:0]       ctl_wr_data;
    logic [7:0]       ctl_rd_data;
    logic             pen_wr_en;
    logic [PER_W-1:0] pen_wr_data;
    logic [PER_W-1:0] pen_rd;
    logic             pfl_wr_en;
    logic [PER_W-1:0] pfl_wr_data;
    logic [PER_W-1:0] pfl_rd;
    logic             tmr_ovf_evt;
    logic             ext_pin;
    logic [3:0]       port_hi;
    logic [PER_W-1:0] per_evt;
    logic             insn_boundary;
    logic             retfie;
    logic             irq_req;
    logic             irq_take;
    logic [PC_W-1:0]  irq_vector;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_ctl_unit #(.PER_W(PER_W), .PC_W(PC_W)) u_irq_ctl_unit (.*);

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = v;
        @(negedge clk); ctl_wr_en = 1'b0;
    endtask

    task automatic wr_pen(input logic [PER_W-1:0] v);
        @(negedge clk); pen_wr_en = 1'b1; pen_wr_data = v;
        @(negedge clk); pen_wr_en = 1'b0;
    endtask

    task automatic wr_pfl(input logic [PER_W-1:0] v);
        @(negedge clk); pfl_wr_en = 1'b1; pfl_wr_data = v;
        @(negedge clk); pfl_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 ctl", ctl_rd_data, 0);
        check("R1 pen", pen_rd, 0);
        check("R1 pfl", pfl_rd, 0);
        check("R1 req", irq_req, 0);
        check("R1 take", irq_take, 0);
    endtask

    task automatic t_layout;
        wr_ctl(8'h5A);
        check("R2 readback 5A", ctl_rd_data, 8'h5A);
        wr_ctl(8'h00);
        check("R2 readback 00", ctl_rd_data, 8'h00);
    endtask

    task automatic t_flag_no_enable;
        wr_ctl(8'h80);
        @(negedge clk); tmr_ovf_evt = 1'b1;
        @(negedge clk); tmr_ovf_evt = 1'b0;
        check("R3 flag without enable", ctl_rd_data, 8'h84);
        check("R3 no request", irq_req, 0);
        wr_ctl(8'hA4);
        #1 check("R8 enabled pending requests", irq_req, 1);
        tick(3);
        check("R8 request holds", irq_req, 1);
        wr_ctl(8'hA0);
        #1 check("R8 cleared flag drops request", irq_req, 0);
        wr_ctl(8'h00);
    endtask

    task automatic t_set_priority;
        wr_ctl(8'h04);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = 8'h00; tmr_ovf_evt = 1'b1;
        @(negedge clk); ctl_wr_en = 1'b0; tmr_ovf_evt = 1'b0;
        check("R4 event beats clear", ctl_rd_data, 8'h04);
        wr_ctl(8'h00);
    endtask

    task automatic t_ext_edge;
        @(negedge clk); ext_pin = 1'b1;
        tick(2);
        check("R5 not yet after two edges", ctl_rd_data[1], 0);
        tick(1);
        check("R5 set on third edge", ctl_rd_data[1], 1);
        wr_ctl(8'h00);
        @(negedge clk); ext_pin = 1'b0;
        tick(6);
        check("R5 falling edge ignored", ctl_rd_data, 8'h00);
    endtask

    task automatic t_port_change;
        @(negedge clk); port_hi = 4'b0100;
        tick(2);
        check("R6 not yet", ctl_rd_data[0], 0);
        tick(1);
        check("R6 rise change", ctl_rd_data[0], 1);
        wr_ctl(8'h00);
        check("R6 cleared", ctl_rd_data[0], 0);
        @(negedge clk); port_hi = 4'b0000;
        tick(3);
        check("R6 fall change", ctl_rd_data[0], 1);
        wr_ctl(8'h00);
    endtask

    task automatic t_periph;
        wr_ctl(8'hC0);
        @(negedge clk); per_evt = 4'b0010;
        @(negedge clk); per_evt = 4'b0000;
        check("R7 flag without enable", pfl_rd, 4'b0010);
        check("R7 no request", irq_req, 0);
        wr_pen(4'b0010);
        #1 check("R7 enabled peripheral requests", irq_req, 1);
        wr_ctl(8'h80);
        #1 check("R7 group enable masks", irq_req, 0);
        wr_pfl(4'b0000);
        wr_pen(4'b0000);
        wr_ctl(8'h00);
    endtask

    task automatic t_take;
        wr_ctl(8'hA4);
        insn_boundary = 1'b0;
        #1 check("R9 request offered", irq_req, 1);
        check("R9 no take off boundary", irq_take, 0);
        tick(2);
        check("R9 gie kept until boundary", ctl_rd_data[7], 1);
        insn_boundary = 1'b1;
        #1 check("R9 take pulses", irq_take, 1);
        check("R9 vector", irq_vector, 4);
        @(negedge clk); insn_boundary = 1'b0;
        check("R9 gie cleared, flags kept", ctl_rd_data, 8'h24);
        check("R9 request dropped", irq_req, 0);
        @(negedge clk); retfie = 1'b1;
        @(negedge clk); retfie = 1'b0;
        check("R10 gie restored", ctl_rd_data, 8'hA4);
        check("R10 pending re-requests", irq_req, 1);
        wr_ctl(8'h00);
    endtask

    task automatic t_gie_block;
        wr_ctl(8'h24);
        #1 check("R11 single source blocked", irq_req, 0);
        wr_ctl(8'h7F);
        #1 check("R11 all sources blocked", irq_req, 0);
        wr_ctl(8'h00);
    endtask

    initial begin
        rst = 1'b1;
        ctl_wr_en = 0; ctl_wr_data = 0; pen_wr_en = 0; pen_wr_data = 0;
        pfl_wr_en = 0; pfl_wr_data = 0; tmr_ovf_evt = 0; ext_pin = 0;
        port_hi = 0; per_evt = 0; insn_boundary = 0; retfie = 0;
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_layout();
        t_flag_no_enable();
        t_set_priority();
        t_ext_edge();
        t_port_change();
        t_periph();
        t_take();
        t_gie_block();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule